// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Framing-Error Flag

This block is the receive half of a classic 8-bit-controller serial port. It watches an asynchronous serial line, rebuilds frames of 8 or 9 data bits from a 16x oversampling tick supplied from outside, and places the received byte in a buffer register. Completion sets a flag that stays set until software clears it. The ninth received bit is kept in its own control bit.

Framing-error detection is optional. A separate power-control register holds the enable bit. When detection is on, the top bit of the control register reads and writes a sticky framing-error flag instead of the high mode bit. The mode bit keeps its value underneath and still selects the frame format.

Software reaches the block through a plain register port. Writes take effect on the clock edge. Reads are combinational on the address. There is no streaming interface: the receive buffer is overwritten by each new frame, so software must read it before the next frame completes.

Top module: `serial_rx_port`

## Requirements
- R1: The line passes through a two-flop synchronizer. It is sampled once per `baud_tick`. The tick on which an idle receiver first sees 0 is sample 0 of the start bit, and each bit lasts 16 ticks. Each bit's value is the majority of its samples 7, 8 and 9; samples outside that window have no effect.
- R2: The mode is the control-register field {bit7 mode-high, bit6 mode-low}. Mode 01 frames carry 8 data bits, and modes 10 and 11 frames carry 9 data bits. Data is sent LSB first, between a start bit and a stop bit. The low 8 data bits are loaded into the buffer register (address 1) at the stop-bit sample.
- R3: Control bit 2 takes the ninth data bit in modes 10 and 11, and the stop-bit value in mode 01.
- R4: Control bit 0 (receive done) is set at the stop-bit sample. It stays set until software writes 0 to it.
- R5: A start bit whose majority reads 1 is a false start. The receiver goes idle and changes no flag and no buffer.
- R6: Control bit 4 (receive enable) must be 1 for a start to be accepted, and mode 00 accepts no frames. Frames sent while reception is disabled change neither the flags nor the buffer.
- R7: Framing-error detection is on only while power-control bit 6 (address 2) is 1. While it is on, a stop bit that reads 0 sets the framing-error flag.
- R8: The framing-error flag is sticky. Later good frames leave it set, and only reset or a software write of 0 clears it.
- R9: Control bit 7 reaches the framing-error flag while power-control bit 6 is 1, and the mode-high bit while it is 0. Neither register is changed by an access made through the other.
- R10: When a frame completes in the same cycle as a control write, the hardware setting of receive done and of the framing-error flag takes priority over the written 0.
- R11: After reset, the control, buffer and power-control registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 receive buffer (read only), 2 power control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |

## Verification
Frame completion at the stop-bit sample can land in the same cycle as a software write to the control register that clears receive done and the framing-error flag. The bench provokes this by holding a clearing write active on every cycle of a stop bit that is known to be bad, with detection enabled. It then watches the read port on each cycle. A done flag that ever reads 1 while the write is still held shows that the hardware set took priority. That same read must also show the framing-error flag as 1.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_BUF = 2'd1;
  localparam logic [1:0] ADDR_PWR = 2'd2;

  localparam int CTL_MODE_HI = 7;
  localparam int CTL_MODE_LO = 6;
  localparam int CTL_RX_EN   = 4;
  localparam int CTL_BIT9    = 2;
  localparam int CTL_DONE    = 0;
  localparam int PWR_FE_EN   = 6;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              go,
  input  logic              nine,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_rb8,
  output logic              frame_stop,
  output logic              busy
);
  localparam int CNT_W = $clog2(OVS);
  localparam int MID   = OVS / 2;
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] S_A  = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] S_B  = CNT_W'(MID);
  localparam logic [CNT_W-1:0] S_C  = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W:0]   shreg;
  logic              samp_a, samp_b, nine_q, stop_q;
  logic              vote;
  logic [IDX_W-1:0]  nbits;

  assign vote  = (samp_a & samp_b) | (samp_a & line) | (samp_b & line);
  assign nbits = nine_q ? IDX_W'(DATA_W + 1) : IDX_W'(DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      samp_a     <= 1'b1;
      samp_b     <= 1'b1;
      nine_q     <= 1'b0;
      stop_q     <= 1'b1;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (tick) begin
        if (state == RX_IDLE) begin
          if (go && !line) begin
            state  <= RX_START;
            cnt    <= CNT_W'(1);
            idx    <= '0;
            nine_q <= nine;
          end
        end else begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt == S_A) samp_a <= line;
          if (cnt == S_B) samp_b <= line;
          if (cnt == S_C) begin
            unique case (state)
              RX_START: if (vote) state <= RX_IDLE;
              RX_DATA: begin
                shreg <= {vote, shreg[DATA_W:1]};
                idx   <= idx + 1'b1;
              end
              RX_STOP: begin
                stop_q     <= vote;
                frame_done <= 1'b1;
                state      <= RX_IDLE;
              end
              default: state <= RX_IDLE;
            endcase
          end
          if (cnt == LAST) begin
            if (state == RX_START) state <= RX_DATA;
            else if (state == RX_DATA && idx == nbits) state <= RX_STOP;
          end
        end
      end
    end
  end

  assign frame_data = nine_q ? shreg[DATA_W-1:0] : shreg[DATA_W:1];
  assign frame_rb8  = nine_q ? shreg[DATA_W] : stop_q;
  assign frame_stop = stop_q;
  assign busy       = (state != RX_IDLE);
endmodule

// File: rtl/rx_ctrl_regs.sv
module rx_ctrl_regs
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_rb8,
  input  logic              frame_stop,
  output logic [7:0]        rdata,
  output logic [1:0]        mode,
  output logic              rx_en,
  output logic              fe_en,
  output logic              fe_flag,
  output logic              sm0,
  output logic              done
);
  logic              sm1, rb8;
  logic [DATA_W-1:0] rbuf;
  logic              ctl_wr, pwr_wr;

  assign ctl_wr = wr && (addr == ADDR_CTL);
  assign pwr_wr = wr && (addr == ADDR_PWR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sm0     <= 1'b0;
      sm1     <= 1'b0;
      rx_en   <= 1'b0;
      fe_en   <= 1'b0;
      fe_flag <= 1'b0;
      rb8     <= 1'b0;
      done    <= 1'b0;
      rbuf    <= '0;
    end else begin
      if (pwr_wr) fe_en <= wdata[PWR_FE_EN];
      if (ctl_wr) begin
        sm1   <= wdata[CTL_MODE_LO];
        rx_en <= wdata[CTL_RX_EN];
        if (!fe_en) sm0 <= wdata[CTL_MODE_HI];
      end
      if (frame_done && fe_en && !frame_stop) fe_flag <= 1'b1;
      else if (ctl_wr && fe_en)               fe_flag <= wdata[CTL_MODE_HI];
      if (frame_done) begin
        done <= 1'b1;
        rb8  <= frame_rb8;
        rbuf <= frame_data;
      end else if (ctl_wr) begin
        done <= wdata[CTL_DONE];
        rb8  <= wdata[CTL_BIT9];
      end
    end
  end

  assign mode = {sm0, sm1};

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTL: begin
        rdata[CTL_MODE_HI] = fe_en ? fe_flag : sm0;
        rdata[CTL_MODE_LO] = sm1;
        rdata[CTL_RX_EN]   = rx_en;
        rdata[CTL_BIT9]    = rb8;
        rdata[CTL_DONE]    = done;
      end
      ADDR_BUF: rdata = 8'(rbuf);
      ADDR_PWR: rdata[PWR_FE_EN] = fe_en;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  logic              line_s;
  logic              frame_done, frame_rb8, frame_stop, rx_busy;
  logic [DATA_W-1:0] frame_data;
  logic [1:0]        mode;
  logic              rx_en, fe_en, fe_flag, sm0, done_flag, rx_go;

  assign rx_go = rx_en && (mode != 2'b00);

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rxd), .d_sync(line_s)
  );

  rx_frame_fsm #(.OVS(OVS), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(line_s),
    .go(rx_go), .nine(mode[1]),
    .frame_done(frame_done), .frame_data(frame_data),
    .frame_rb8(frame_rb8), .frame_stop(frame_stop), .busy(rx_busy)
  );

  rx_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .frame_done(frame_done), .frame_data(frame_data),
    .frame_rb8(frame_rb8), .frame_stop(frame_stop), .rdata(reg_rdata),
    .mode(mode), .rx_en(rx_en), .fe_en(fe_en), .fe_flag(fe_flag),
    .sm0(sm0), .done(done_flag)
  );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       fe_en,
  input logic       fe_flag,
  input logic       sm0,
  input logic       done,
  input logic       frame_done,
  input logic       busy,
  input logic       rx_go
);
  logic ctl_wr;
  assign ctl_wr = reg_wr && (reg_addr == 2'd0);

  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctl_wr) |=> done);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_fe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_flag && !(ctl_wr && fe_en)) |=> fe_flag);

  p_fe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_flag && !fe_en) |=> !fe_flag);

  p_sm0_alias_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && fe_en) |=> $stable(sm0));

  p_fe_alias_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !fe_en && !frame_done) |=> $stable(fe_flag));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> done);

  p_idle_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rx_go) |=> !busy);
endmodule

bind serial_rx_port serial_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .fe_en(fe_en), .fe_flag(fe_flag), .sm0(sm0), .done(done_flag),
  .frame_done(frame_done), .busy(rx_busy), .rx_go(rx_go)
);

// File: tb/serial_rx_port_bench.sv
`timescale 1ns/1ps
module serial_rx_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] div = 2'd0;
  logic       stop_phase = 1'b0;
  int         n_tests = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    div       <= div + 2'd1;
    baud_tick <= (div == 2'd3);
  end

  serial_rx_port u_serial_rx_port (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       fe_en;
    logic       fe_wr;
    logic [8:0] din;
    logic       stop;
    logic [7:0] exp_buf;
    logic       exp_rb8;
    logic       exp_b7;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0, 1'b0, 9'h0A5, 1'b1, 8'hA5, 1'b1, 1'b0},
    '{2'b10, 1'b0, 1'b0, 9'h13C, 1'b1, 8'h3C, 1'b1, 1'b1},
    '{2'b11, 1'b1, 1'b0, 9'h0C3, 1'b1, 8'hC3, 1'b0, 1'b0},
    '{2'b11, 1'b1, 1'b0, 9'h15A, 1'b0, 8'h5A, 1'b1, 1'b1},
    '{2'b01, 1'b1, 1'b1, 9'h00F, 1'b1, 8'h0F, 1'b1, 1'b1},
    '{2'b10, 1'b1, 1'b0, 9'h080, 1'b1, 8'h80, 1'b0, 1'b0},
    '{2'b01, 1'b0, 1'b0, 9'h0FF, 1'b0, 8'hFF, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic next_tick();
    @(posedge clk iff baud_tick);
    #1;
  endtask

  // gbit: frame bit index (0 = start) whose samples in gmask are inverted
  task automatic send_frame(input logic [8:0] d, input int nbits, input logic stop,
                            input int gbit, input logic [15:0] gmask);
    next_tick();
    for (int b = 0; b < nbits + 2; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == nbits + 1) ? stop : d[b-1];
      if (b == nbits + 1) stop_phase = 1'b1;
      for (int k = 0; k < 16; k++) begin
        rxd = (b == gbit && gmask[k]) ? ~v : v;
        next_tick();
      end
    end
    rxd = 1'b1;
    repeat (6) next_tick();
    stop_phase = 1'b0;
  endtask

  task automatic setup(input logic [1:0] mode, input logic rxen, input logic fe_en,
                       input logic fe_wr);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, {mode, 1'b0, rxen, 4'b0000});
    wr_reg(2'd2, {1'b0, fe_en, 6'b0});
    if (fe_en) wr_reg(2'd0, {fe_wr, mode[0], 1'b0, rxen, 4'b0000});
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r, b0;
    bit seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd_reg(2'd0, r); check("R11 ctl", r, 8'h00);
    rd_reg(2'd1, r); check("R11 buf", r, 8'h00);
    rd_reg(2'd2, r); check("R11 pwr", r, 8'h00);

    // Table: R2 R3 R4 R7 across modes and stop values
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].mode, 1'b1, VECS[i].fe_en, VECS[i].fe_wr);
      send_frame(VECS[i].din, (VECS[i].mode == 2'b01) ? 8 : 9, VECS[i].stop, -1, 16'h0);
      rd_reg(2'd1, r); check("R2 buffer", r, VECS[i].exp_buf);
      rd_reg(2'd0, r);
      check("R4 done", {7'b0, r[0]}, 8'h01);
      check("R3 ninth bit", {7'b0, r[2]}, {7'b0, VECS[i].exp_rb8});
      check("R7 bit7", {7'b0, r[7]}, {7'b0, VECS[i].exp_b7});
    end

    // R1 majority: stray samples outside or single inside have no effect
    setup(2'b01, 1'b1, 1'b0, 1'b0);
    send_frame(9'h055, 8, 1'b1, 1, 16'h0540);
    rd_reg(2'd1, r); check("R1 single glitch", r, 8'h55);
    wr_reg(2'd0, 8'h50);
    send_frame(9'h055, 8, 1'b1, 2, 16'h0180);
    rd_reg(2'd1, r); check("R1 two-sample flip", r, 8'h57);

    // R5 false start
    wr_reg(2'd0, 8'h50);
    rd_reg(2'd1, b0);
    next_tick();
    rxd = 1'b0; repeat (5) next_tick();
    rxd = 1'b1; repeat (30) next_tick();
    rd_reg(2'd0, r); check("R5 no done", {7'b0, r[0]}, 8'h00);
    rd_reg(2'd1, r); check("R5 buffer kept", r, b0);

    // R6 reception disabled, then mode 00
    wr_reg(2'd0, 8'h40);
    send_frame(9'h099, 8, 1'b1, -1, 16'h0);
    rd_reg(2'd0, r); check("R6 rx_en off done", {7'b0, r[0]}, 8'h00);
    rd_reg(2'd1, r); check("R6 rx_en off buffer", r, b0);
    wr_reg(2'd0, 8'h10);
    send_frame(9'h066, 8, 1'b1, -1, 16'h0);
    rd_reg(2'd0, r); check("R6 mode00 done", {7'b0, r[0]}, 8'h00);
    rd_reg(2'd1, r); check("R6 mode00 buffer", r, b0);

    // R9 alias
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h80);
    rd_reg(2'd0, r); check("R9 mode-high set", {7'b0, r[7]}, 8'h01);
    wr_reg(2'd2, 8'h40);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, r); check("R9 fe view clear", {7'b0, r[7]}, 8'h00);
    wr_reg(2'd0, 8'h80);
    rd_reg(2'd0, r); check("R9 fe view set", {7'b0, r[7]}, 8'h01);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h40);
    rd_reg(2'd0, r); check("R9 fe untouched by mode write", {7'b0, r[7]}, 8'h01);

    // R7 detection disabled: bad stop leaves flag clear
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h50);
    send_frame(9'h011, 8, 1'b0, -1, 16'h0);
    wr_reg(2'd2, 8'h40);
    rd_reg(2'd0, r); check("R7 disabled no fe", {7'b0, r[7]}, 8'h00);

    // R8 sticky then software clear
    wr_reg(2'd0, 8'h50);
    send_frame(9'h022, 8, 1'b0, -1, 16'h0);
    rd_reg(2'd0, r); check("R8 fe set", {7'b0, r[7]}, 8'h01);
    wr_reg(2'd0, 8'hD0);
    send_frame(9'h033, 8, 1'b1, -1, 16'h0);
    rd_reg(2'd0, r); check("R8 fe survives good frame", {7'b0, r[7]}, 8'h01);
    wr_reg(2'd0, 8'h50);
    rd_reg(2'd0, r); check("R8 fe cleared by write", {7'b0, r[7]}, 8'h00);

    // R10 completion vs. clearing write in the same cycle
    seen = 1'b0;
    fork
      send_frame(9'h03C, 8, 1'b0, -1, 16'h0);
      begin
        wait (stop_phase);
        for (int c = 0; c < 120 && !seen; c++) begin
          @(negedge clk);
          #1;
          if (reg_wr && reg_rdata[0]) begin
            seen = 1'b1;
            check("R10 fe wins", {7'b0, reg_rdata[7]}, 8'h01);
            reg_wr = 1'b0;
          end else begin
            reg_addr = 2'd0; reg_wdata = 8'h50; reg_wr = 1'b1;
          end
        end
        reg_wr = 1'b0;
      end
    join
    check("R10 done wins", {7'b0, seen}, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule